// File: doc/BRIEF.md
# Dynamic On-Die Termination Sequencer

This controller-side block drives the termination-enable pin of a DDR3-class DRAM and predicts, cycle by cycle, which termination the DRAM is applying on its data lines: none, the nominal termination, or the write termination. Termination may be requested for reasons other than writing, such as another rank being read. Write commands arrive with a flag that selects an eight-beat burst or a four-beat chopped burst. The block raises the pin for every write, holds it for the minimum time that the write needs, and tracks the switch from nominal to write termination and back.

Both changes of the pin take effect in the model after a delay of write latency minus two clocks. The write latency is the sum of the CAS write latency and the additive latency. Both values are captured while reset is asserted and are static after that. A sticky flag reports when the pin was released before its minimum high time had elapsed.

Top module: `odt_dyn_seq`

## Requirements
- R1: `cfg_cwl` and `cfg_al` are captured on every clock edge while `rst` is high and are ignored after reset is released. The lag D equals cfg_cwl + cfg_al − 2, or 0 if that sum is below 2.
- R2: `odt_pin` is high in the cycle after any edge that samples `term_req` or `wr_cmd` high. Without a write, it is low in the cycle after the edge that samples `term_req` low.
- R3: A write with `wr_bl8`=1 keeps `odt_pin` high for at least 6 consecutive cycles, starting in the cycle after the write is sampled.
- R4: A write with `wr_bl8`=0 (chopped burst) keeps `odt_pin` high for at least 4 consecutive cycles, starting in the cycle after the write is sampled.
- R5: Without writes, `term_state` in cycle t equals nominal (2'b01) if `odt_pin` was high in cycle t−D. Otherwise it equals off (2'b00).
- R6: A write whose pin window begins in cycle w gives `term_state` = write (2'b10) in cycles w+D up to w+D+5 for an eight-beat burst. For a chopped burst the window is w+D up to w+D+3.
- R7: When a write window ends, `term_state` returns to nominal if the pin was held high by `term_req` D cycles earlier. Otherwise it returns to off.
- R8: A write that arrives while an earlier write window is still open extends the window so that it ends at the later of the two windows' ends.
- R9: `rule_viol` rises in the cycle in which `odt_pin` falls after fewer than 4 high cycles. It stays high until reset.
- R10: `term_state` never takes the value 2'b11.
- R11: While `rst` is high, and in the first cycle after it is released with idle inputs, `odt_pin`=0, `term_state`=2'b00 and `rule_viol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_cwl | input | LAT_W | CAS write latency in clocks |
| cfg_al | input | LAT_W | Additive latency in clocks |
| wr_cmd | input | 1 | Write command issued this cycle |
| wr_bl8 | input | 1 | 1 = eight-beat burst, 0 = chopped four-beat burst |
| term_req | input | 1 | Request to keep termination on for non-write reasons |
| odt_pin | output | 1 | Level driven onto the DRAM termination-enable pin |
| term_state | output | 2 | Predicted termination: 00 off, 01 nominal, 10 write |
| rule_viol | output | 1 | Sticky flag: pin released before its minimum high time |

## Verification
A corrupted hold counter shows up on `odt_pin` in the cycle after the write. The pin drops after fewer than six or four cycles, or it stays high too long. The same error then reappears D cycles later as a write-termination window of the wrong length. A wrong delay tap, or a configuration that drifts after reset, shifts every nominal and write edge of `term_state` against the pin by a fixed number of cycles. Comparing the pin and the state in every cycle of each trace therefore catches such errors on the first edge they affect.

// File: rtl/odt_seq_pkg.sv
package odt_seq_pkg;

    typedef enum logic [1:0] {
        TERM_OFF = 2'b00,
        TERM_NOM = 2'b01,
        TERM_WR  = 2'b10
    } term_e;

    localparam int BL8_HOLD = 6;
    localparam int BC4_HOLD = 4;
    localparam int MIN_HIGH = 4;

    typedef struct packed {
        logic pin;
        logic wr_act;
    } drive_t;

    function automatic int unsigned hold_load(input logic bl8);
        return bl8 ? BL8_HOLD - 1 : BC4_HOLD - 1;
    endfunction

endpackage

// File: rtl/odt_pin_drive.sv
module odt_pin_drive
    import odt_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   term_req,
    input  logic   wr_cmd,
    input  logic   wr_bl8,
    output drive_t drv,
    output logic   viol
);
    localparam int HOLD_W = $clog2(BL8_HOLD);
    localparam int RUN_W  = $clog2(BL8_HOLD + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic [HOLD_W-1:0] hold_q, hold_d, hold_dec, hold_ld;
    logic [RUN_W-1:0]  run_q, run_d, min_q, min_d;
    logic              pin_d, wact_d, viol_d, fall_early;

    always_comb begin
        hold_dec = (hold_q != '0) ? hold_q - 1'b1 : '0;
        hold_ld  = HOLD_W'(hold_load(wr_bl8));
        hold_d   = hold_dec;
        if (wr_cmd && hold_ld > hold_dec) hold_d = hold_ld;
        wact_d   = wr_cmd | (hold_q != '0);
        pin_d    = term_req | wact_d;
        if (!pin_d)             run_d = '0;
        else if (!drv.pin)      run_d = RUN_W'(1);
        else if (run_q == RUN_MAX) run_d = run_q;
        else                    run_d = run_q + 1'b1;
        if (pin_d && !drv.pin)
            min_d = (wr_cmd && wr_bl8) ? RUN_W'(BL8_HOLD) : RUN_W'(MIN_HIGH);
        else
            min_d = min_q;
        fall_early = drv.pin && !pin_d && (run_q < min_q);
        viol_d     = viol | fall_early;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            run_q      <= '0;
            min_q      <= RUN_W'(MIN_HIGH);
            drv.pin    <= 1'b0;
            drv.wr_act <= 1'b0;
            viol       <= 1'b0;
        end else begin
            hold_q     <= hold_d;
            run_q      <= run_d;
            min_q      <= min_d;
            drv.pin    <= pin_d;
            drv.wr_act <= wact_d;
            viol       <= viol_d;
        end
    end

    // R2
    wr_pin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> drv.pin);

    // R3
    hold_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q != '0) |-> (drv.pin && drv.wr_act));

    // R9
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);

    // R9
    early_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.pin) |-> (viol || $past(run_q) >= RUN_W'(MIN_HIGH)));

endmodule

// File: rtl/odt_lag.sv
module odt_lag #(
    parameter int DEPTH = 28,
    localparam int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    logic [DEPTH:0] tap;

    assign tap[0] = din;

    for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) tap[k] <= 1'b0;
            else     tap[k] <= tap[k-1];
        end
    end

    assign dout = tap[sel];

    // R5
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        sel <= SEL_W'(DEPTH));

endmodule

// File: rtl/odt_dyn_seq.sv
module odt_dyn_seq
    import odt_seq_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAT_W-1:0] cfg_cwl,
    input  logic [LAT_W-1:0] cfg_al,
    input  logic             wr_cmd,
    input  logic             wr_bl8,
    input  logic             term_req,
    output logic             odt_pin,
    output logic [1:0]       term_state,
    output logic             rule_viol
);
    localparam int DEPTH = 2 * ((1 << LAT_W) - 1) - 2;
    localparam int SEL_W = $clog2(DEPTH + 1);

    logic [LAT_W-1:0] cwl_q, al_q;
    logic [LAT_W:0]   wl, dly_full;
    logic [SEL_W-1:0] dly;
    drive_t           drv;
    logic             nom_tap, wr_tap;
    term_e            st;

    always_ff @(posedge clk) begin
        if (rst) begin
            cwl_q <= cfg_cwl;
            al_q  <= cfg_al;
        end
    end

    always_comb begin
        wl       = {1'b0, cwl_q} + {1'b0, al_q};
        dly_full = (wl >= (LAT_W+1)'(2)) ? wl - (LAT_W+1)'(2) : '0;
        dly      = SEL_W'(dly_full);
    end

    odt_pin_drive u_drive (
        .clk      (clk),
        .rst      (rst),
        .term_req (term_req),
        .wr_cmd   (wr_cmd),
        .wr_bl8   (wr_bl8),
        .drv      (drv),
        .viol     (rule_viol)
    );

    odt_lag #(.DEPTH(DEPTH)) u_nom_lag (
        .clk  (clk),
        .rst  (rst),
        .din  (drv.pin),
        .sel  (dly),
        .dout (nom_tap)
    );

    odt_lag #(.DEPTH(DEPTH)) u_wr_lag (
        .clk  (clk),
        .rst  (rst),
        .din  (drv.wr_act),
        .sel  (dly),
        .dout (wr_tap)
    );

    always_comb begin
        if (wr_tap)       st = TERM_WR;
        else if (nom_tap) st = TERM_NOM;
        else              st = TERM_OFF;
    end

    assign odt_pin    = drv.pin;
    assign term_state = st;

    // R10
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        term_state != 2'b11);

    // R6
    wr_needs_nom_chk: assert property (@(posedge clk) disable iff (rst)
        wr_tap |-> nom_tap);

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(cwl_q) && $stable(al_q)));

endmodule

// File: tb/odt_dyn_seq_tb.sv
module odt_dyn_seq_tb;
    localparam int LAT_W = 4;
    localparam int TLEN  = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LAT_W-1:0] cfg_cwl = 4'd5;
    logic [LAT_W-1:0] cfg_al  = 4'd0;
    logic             wr_cmd = 1'b0, wr_bl8 = 1'b0, term_req = 1'b0;
    logic             odt_pin, rule_viol;
    logic [1:0]       term_state;

    int n_chk = 0;
    int n_fail = 0;
    int dly = 3;

    logic s_req [TLEN];
    logic s_wr  [TLEN];
    logic s_bl8 [TLEN];
    logic g_pin [TLEN];
    logic [1:0] g_st [TLEN];

    always #5 clk = ~clk;

    odt_dyn_seq #(.LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_cwl(cfg_cwl), .cfg_al(cfg_al),
        .wr_cmd(wr_cmd), .wr_bl8(wr_bl8), .term_req(term_req),
        .odt_pin(odt_pin), .term_state(term_state), .rule_viol(rule_viol)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int cwl, input int al);
        @(negedge clk);
        rst = 1'b1; wr_cmd = 0; wr_bl8 = 0; term_req = 0;
        cfg_cwl = LAT_W'(cwl); cfg_al = LAT_W'(al);
        dly = (cwl + al >= 2) ? cwl + al - 2 : 0;
        repeat (3) @(negedge clk);
        chk(odt_pin == 0 && term_state == 2'b00 && rule_viol == 0, "R11 in reset",
            {odt_pin, term_state, rule_viol}, 0);
        rst = 1'b0;
    endtask

    task automatic clear_stim();
        for (int i = 0; i < TLEN; i++) begin
            s_req[i] = 0; s_wr[i] = 0; s_bl8[i] = 0;
        end
    endtask

    function automatic logic wr_on(input int t);
        for (int j = 0; j <= t; j++)
            if (s_wr[j] && (t - j) < (s_bl8[j] ? 6 : 4)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic exp_pin(input int i);
        if (i < 1) return 1'b0;
        return s_req[i-1] | wr_on(i-1);
    endfunction

    function automatic logic [1:0] exp_state(input int i);
        int k = i - dly;
        if (k < 1) return 2'b00;
        if (wr_on(k-1)) return 2'b10;
        if (exp_pin(k)) return 2'b01;
        return 2'b00;
    endfunction

    task automatic run_trace(input string pin_tag, input string st_tag);
        for (int i = 0; i < TLEN; i++) begin
            @(negedge clk);
            g_pin[i] = odt_pin;
            g_st[i]  = term_state;
            term_req = s_req[i];
            wr_cmd   = s_wr[i];
            wr_bl8   = s_bl8[i];
        end
        for (int i = 0; i < TLEN; i++) begin
            chk(g_pin[i] == exp_pin(i), pin_tag, g_pin[i], exp_pin(i));
            chk(g_st[i] == exp_state(i), st_tag, g_st[i], exp_state(i));
        end
    endtask

    task automatic t_reset_state();
        do_reset(5, 0);
        @(negedge clk);
        chk(odt_pin == 0, "R11 pin after reset", odt_pin, 0);
        chk(term_state == 2'b00, "R11 state after reset", term_state, 0);
        chk(rule_viol == 0, "R11 viol after reset", rule_viol, 0);
    endtask

    task automatic t_nominal(input int cwl, input int al);
        do_reset(cwl, al);
        clear_stim();
        for (int i = 2; i < 10; i++) s_req[i] = 1;
        run_trace("R2 nominal pin", "R5 nominal state");
        chk(rule_viol == 0, "R9 no viol", rule_viol, 0);
    endtask

    task automatic t_single_write(input logic bl8);
        do_reset(5, 0);
        clear_stim();
        s_wr[3] = 1; s_bl8[3] = bl8;
        if (bl8) run_trace("R3 bl8 pin", "R6 bl8 window");
        else     run_trace("R4 bc4 pin", "R6 bc4 window");
        chk(rule_viol == 0, "R9 no viol after write", rule_viol, 0);
    endtask

    task automatic t_write_in_nominal();
        do_reset(6, 2);
        clear_stim();
        for (int i = 1; i < 18; i++) s_req[i] = 1;
        s_wr[5] = 1; s_bl8[5] = 1;
        s_wr[12] = 1; s_bl8[12] = 0;
        run_trace("R2 pin with request", "R7 return to nominal");
    endtask

    task automatic t_extend();
        do_reset(5, 0);
        clear_stim();
        s_wr[1] = 1; s_bl8[1] = 1;
        s_wr[4] = 1; s_bl8[4] = 0;
        s_wr[14] = 1; s_bl8[14] = 0;
        s_wr[16] = 1; s_bl8[16] = 1;
        s_wr[26] = 1; s_bl8[26] = 1;
        s_wr[27] = 1; s_bl8[27] = 0;
        run_trace("R8 extended pin", "R8 extended window");
    endtask

    task automatic t_cfg_ignored();
        do_reset(5, 0);
        cfg_cwl = 4'd15; cfg_al = 4'd15;
        clear_stim();
        for (int i = 2; i < 7; i++) s_req[i] = 1;
        s_wr[10] = 1; s_bl8[10] = 1;
        run_trace("R1 pin", "R1 lag unchanged");
    endtask

    task automatic t_violation();
        do_reset(5, 0);
        clear_stim();
        for (int i = 1; i < 5; i++) s_req[i] = 1;
        run_trace("R2 four-cycle pin", "R5 four-cycle state");
        chk(rule_viol == 0, "R9 four cycles legal", rule_viol, 0);
        @(negedge clk); term_req = 1;
        @(negedge clk);
        @(negedge clk); term_req = 0;
        @(negedge clk);
        chk(odt_pin == 0, "R9 pin dropped", odt_pin, 0);
        chk(rule_viol == 1, "R9 early drop flagged", rule_viol, 1);
        repeat (6) @(negedge clk);
        chk(rule_viol == 1, "R9 flag sticky", rule_viol, 1);
        do_reset(5, 0);
        @(negedge clk);
        chk(rule_viol == 0, "R9 cleared by reset", rule_viol, 0);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none
        t_reset_state();
        t_nominal(5, 0);
        t_nominal(6, 2);
        t_nominal(2, 0);
        t_single_write(1'b1);
        t_single_write(1'b0);
        t_write_in_nominal();
        t_extend();
        t_cfg_ignored();
        t_violation();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule